// File: doc/BRIEF.md
# Stack Push Execution Unit

This unit carries out one already-decoded push operation. From the source value, the kind of source, the operand size, the current processor mode and the current stack pointer, it works out the lowered stack pointer and issues a single memory write at that address. The write carries the data, a byte-enable mask and a size code. The data is widened as the source kind requires: immediates are sign-extended, segment selectors are zero-extended or written as a bare 16-bit store, and the pointer itself is written as it stood before the push.

The stack pointer moves down by the operand width in bytes. The subtraction only affects the low 16, 32 or 64 bits selected by the stack-address size, and any bits above that width are kept as they were. In real-address mode, a pointer that equals 1 raises a stack fault instead of a write.

A command is accepted on `start` while the unit is idle. The write request then stays up until `mem_ready` completes the handshake, and only then is the new pointer handed back. Paging, segment base addition, alignment checks and all flag outputs are left to other blocks.

Top module: `stack_push_unit`

## Requirements
- R1: The store address is the current pointer minus 2, 4 or 8 for operand size code 0 (16-bit), 1 (32-bit) or 2 (64-bit). The pointer returned on `sp_out` equals that store address.
- R2: The stack-address size is 64 when `long_mode` is 1. Otherwise it is 32 when `stack_big` is 1 and 16 when it is 0. The subtraction wraps within that width, and pointer bits above it are passed through unchanged.
- R3: For `src_kind` 1 (immediate), the value is sign-extended from the width given by `imm_width` (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) before it is written.
- R4: For `src_kind` 2 (segment selector), the low 16 bits of the value are zero-extended. At operand size 32 the write is 16-bit only: byte enables 0x03 and size code 0.
- R5: For `src_kind` 3 (the stack pointer), the data written is the pointer value from before the decrement.
- R6: For `src_kind` 0 (register), the data holds the low operand-size bytes of the value, and higher byte lanes are zero. The byte enables are 0x03, 0x0F or 0xFF, and `mem_size` equals the operand size code.
- R7: When `real_mode` is 1 and the pointer masked to the stack-address width equals 1, `fault_ss` pulses one cycle after `start`. No write request is made and no pointer is committed.
- R8: `sp_commit` pulses for one cycle, with `sp_out` valid, in the cycle after `mem_req` and `mem_ready` are both high. It never pulses otherwise.
- R9: While `mem_req` waits for `mem_ready`, the address, data and enables hold steady. A `start` that arrives while the unit is busy is ignored.
- R10: The pointer is never rounded. A push narrower than the stack-address width can leave the pointer misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Accept a push command (taken only when idle) |
| src_kind | input | 2 | 0 register, 1 immediate, 2 segment selector, 3 stack pointer |
| imm_width | input | 2 | Immediate width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| op_size | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 bits |
| long_mode | input | 1 | 64-bit mode: the stack-address size is forced to 64 |
| stack_big | input | 1 | Stack segment is 32-bit when not in 64-bit mode |
| real_mode | input | 1 | Real-address mode: enables the pointer-equals-1 fault |
| src_value | input | 64 | Source operand |
| sp_in | input | 64 | Current stack pointer |
| busy | output | 1 | A write request is outstanding |
| mem_req | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write address (the new pointer) |
| mem_data | output | 64 | Write data, in the low byte lanes |
| mem_be | output | 8 | Byte enables |
| mem_size | output | 2 | Store size code: 0 = 16, 1 = 32, 2 = 64 bits |
| sp_out | output | 64 | Committed new stack pointer |
| sp_commit | output | 1 | One-cycle pulse: `sp_out` is updated |
| fault_ss | output | 1 | One-cycle pulse: stack fault, push dropped |

## Verification
Directed pushes try each source kind against every operand size. This separates sign extension (negative immediates of each width), zero extension and the 16-bit-only segment store, register truncation, and writing the pre-decrement pointer. Pointers whose low bits sit at zero, with junk in the upper bits, show whether the subtraction wraps at 16, 32 or 64 bits and whether the upper bits survive. Real-mode pushes with the pointer at exactly 1 and at 2 tell a fault apart from a normal write. Random pushes with random ready delays and a `start` pulsed while busy then exercise the handshake and confirm that the request holds steady.

// File: rtl/stack_push_unit.sv
module stack_push_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  src_kind,
  input  logic [1:0]  imm_width,
  input  logic [1:0]  op_size,
  input  logic        long_mode,
  input  logic        stack_big,
  input  logic        real_mode,
  input  logic [63:0] src_value,
  input  logic [63:0] sp_in,
  output logic        busy,
  output logic        mem_req,
  input  logic        mem_ready,
  output logic [63:0] mem_addr,
  output logic [63:0] mem_data,
  output logic [7:0]  mem_be,
  output logic [1:0]  mem_size,
  output logic [63:0] sp_out,
  output logic        sp_commit,
  output logic        fault_ss
);

  localparam logic [1:0] K_REG = 2'd0;
  localparam logic [1:0] K_IMM = 2'd1;
  localparam logic [1:0] K_SEG = 2'd2;
  localparam logic [1:0] K_SP  = 2'd3;

  logic [63:0] st_mask, lane_mask, sp_dec, sp_next, ext_val;
  logic [3:0]  step;
  logic        seg_narrow, fault_now, accept;
  logic [7:0]  be_next;
  logic [1:0]  size_next;

  assign st_mask = long_mode ? {64{1'b1}} :
                   stack_big ? {32'd0, {32{1'b1}}} : {48'd0, {16{1'b1}}};

  assign step = (op_size == 2'd0) ? 4'd2 : (op_size == 2'd1) ? 4'd4 : 4'd8;

  assign sp_dec  = sp_in - {60'd0, step};
  assign sp_next = (sp_in & ~st_mask) | (sp_dec & st_mask);

  assign seg_narrow = (src_kind == K_SEG) && (op_size == 2'd1);

  always_comb begin
    case (src_kind)
      K_REG: ext_val = src_value;
      K_IMM:
        case (imm_width)
          2'd0:    ext_val = {{56{src_value[7]}},  src_value[7:0]};
          2'd1:    ext_val = {{48{src_value[15]}}, src_value[15:0]};
          2'd2:    ext_val = {{32{src_value[31]}}, src_value[31:0]};
          default: ext_val = src_value;
        endcase
      K_SEG:   ext_val = {48'd0, src_value[15:0]};
      default: ext_val = sp_in;
    endcase
  end

  assign lane_mask = (op_size == 2'd0 || seg_narrow) ? {48'd0, {16{1'b1}}} :
                     (op_size == 2'd1) ? {32'd0, {32{1'b1}}} : {64{1'b1}};

  assign be_next   = (op_size == 2'd0 || seg_narrow) ? 8'h03 :
                     (op_size == 2'd1) ? 8'h0F : 8'hFF;

  assign size_next = seg_narrow ? 2'd0 : (op_size == 2'd3) ? 2'd2 : op_size;

  assign fault_now = real_mode && ((sp_in & st_mask) == 64'd1);

  assign busy   = mem_req;
  assign accept = start && !mem_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_be    <= '0;
      mem_size  <= '0;
      fault_ss  <= 1'b0;
      sp_commit <= 1'b0;
      sp_out    <= '0;
    end else begin
      fault_ss  <= 1'b0;
      sp_commit <= 1'b0;
      if (accept) begin
        if (fault_now) begin
          fault_ss <= 1'b1;
        end else begin
          mem_req  <= 1'b1;
          mem_addr <= sp_next;
          mem_data <= ext_val & lane_mask;
          mem_be   <= be_next;
          mem_size <= size_next;
        end
      end else if (mem_req && mem_ready) begin
        mem_req   <= 1'b0;
        sp_out    <= mem_addr;
        sp_commit <= 1'b1;
      end
    end
  end

  // R9: request payload frozen while waiting for the handshake
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  // R8: a commit only follows a completed handshake
  p_commit_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_commit |-> $past(mem_req && mem_ready));

  // R1: committed pointer is the address that was written
  p_sp_matches_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sp_commit |-> sp_out == $past(mem_addr));

  // R7: a fault never comes with a write or a commit
  p_fault_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ss |-> !mem_req && !sp_commit);

  // R6: byte enables are one of the contiguous low-lane masks
  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 8'h03 || mem_be == 8'h0F || mem_be == 8'hFF));

endmodule

// File: tb/test_stack_push_unit.sv
module test_stack_push_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  src_kind = '0, imm_width = '0, op_size = '0;
  logic        long_mode = 1'b0, stack_big = 1'b0, real_mode = 1'b0;
  logic [63:0] src_value = '0, sp_in = '0;
  logic        busy, mem_req, sp_commit, fault_ss;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_addr, mem_data, sp_out;
  logic [7:0]  mem_be;
  logic [1:0]  mem_size;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stack_push_unit i_stack_push_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .src_kind(src_kind),
    .imm_width(imm_width), .op_size(op_size), .long_mode(long_mode),
    .stack_big(stack_big), .real_mode(real_mode), .src_value(src_value),
    .sp_in(sp_in), .busy(busy), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_size(mem_size), .sp_out(sp_out), .sp_commit(sp_commit),
    .fault_ss(fault_ss)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(
    input logic [1:0] k, input logic [1:0] iw, input logic [1:0] os,
    input logic lm, input logic sb, input logic rm,
    input logic [63:0] v, input logic [63:0] sp,
    output logic [63:0] e_sp, output logic [63:0] e_data,
    output logic [7:0] e_be, output logic [1:0] e_size, output logic e_fault);
    logic [63:0] m, x, d, lanes;
    logic narrow;
    m = lm ? 64'hFFFF_FFFF_FFFF_FFFF : sb ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_0000_FFFF;
    d = sp - ((os == 2'd0) ? 64'd2 : (os == 2'd1) ? 64'd4 : 64'd8);
    e_sp = (sp & ~m) | (d & m);
    narrow = (k == 2'd2) && (os == 2'd1);
    case (k)
      2'd0: x = v;
      2'd1: x = (iw == 2'd0) ? 64'($signed(v[7:0])) :
                (iw == 2'd1) ? 64'($signed(v[15:0])) :
                (iw == 2'd2) ? 64'($signed(v[31:0])) : v;
      2'd2: x = {48'd0, v[15:0]};
      default: x = sp;
    endcase
    lanes = (os == 2'd0 || narrow) ? 64'hFFFF : (os == 2'd1) ? 64'hFFFF_FFFF : '1;
    e_data = x & lanes;
    e_be = (os == 2'd0 || narrow) ? 8'h03 : (os == 2'd1) ? 8'h0F : 8'hFF;
    e_size = narrow ? 2'd0 : os;
    e_fault = rm && ((sp & m) == 64'd1);
  endfunction

  task automatic do_push(
    input logic [1:0] k, input logic [1:0] iw, input logic [1:0] os,
    input logic lm, input logic sb, input logic rm,
    input logic [63:0] v, input logic [63:0] sp, input int wait_n);
    logic [63:0] e_sp, e_data;
    logic [7:0]  e_be;
    logic [1:0]  e_size;
    logic        e_fault;
    string       dtag;
    model(k, iw, os, lm, sb, rm, v, sp, e_sp, e_data, e_be, e_size, e_fault);
    case (k)
      2'd0: dtag = "R6 data";
      2'd1: dtag = "R3 data";
      2'd2: dtag = "R4 data";
      default: dtag = "R5 data";
    endcase
    @(negedge clk);
    src_kind = k; imm_width = iw; op_size = os; long_mode = lm;
    stack_big = sb; real_mode = rm; src_value = v; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (e_fault) begin
      chk(fault_ss == 1'b1, "R7 fault", 64'(fault_ss), 64'd1);
      chk(mem_req == 1'b0, "R7 no request", 64'(mem_req), 64'd0);
      @(negedge clk);
      chk(sp_commit == 1'b0, "R7 no commit", 64'(sp_commit), 64'd0);
    end else begin
      chk(fault_ss == 1'b0, "R7 no fault", 64'(fault_ss), 64'd0);
      chk(mem_req == 1'b1, "R9 request", 64'(mem_req), 64'd1);
      chk(mem_addr == e_sp, "R1 R2 address", mem_addr, e_sp);
      chk(mem_data == e_data, dtag, mem_data, e_data);
      chk(mem_be == e_be, (k == 2'd2) ? "R4 be" : "R6 be", 64'(mem_be), 64'(e_be));
      chk(mem_size == e_size, (k == 2'd2) ? "R4 size" : "R6 size", 64'(mem_size), 64'(e_size));
      for (int i = 0; i < wait_n; i++) begin
        start = 1'b1; src_value = ~v; sp_in = ~sp;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req == 1'b1 && sp_commit == 1'b0, "R8 R9 waiting", 64'(mem_req), 64'd1);
        chk(mem_addr == e_sp && mem_data == e_data, "R9 stable", mem_addr, e_sp);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk(sp_commit == 1'b1, "R8 commit", 64'(sp_commit), 64'd1);
      chk(sp_out == e_sp, "R1 R2 R10 pointer", sp_out, e_sp);
      chk(mem_req == 1'b0, "R8 request dropped", 64'(mem_req), 64'd0);
      @(negedge clk);
      chk(sp_commit == 1'b0, "R8 single pulse", 64'(sp_commit), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0 && sp_commit == 1'b0 && fault_ss == 1'b0, "R8 reset idle",
        {61'd0, mem_req, sp_commit, fault_ss}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", 64'(busy), 64'd0);

    // R3: negative immediates of each width
    do_push(2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 64'h80, 64'h7000, 0);
    do_push(2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 64'h8001, 64'h2000, 1);
    do_push(2'd1, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 64'hF000_0000, 64'h3008, 0);
    do_push(2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h7F, 64'h0010, 0);
    // R4: segment at each size
    do_push(2'd2, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_0012_1234, 64'h4000, 2);
    do_push(2'd2, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 64'hDEAD_BEEF_0012_F234, 64'h4000, 0);
    do_push(2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_8001, 64'h0100, 0);
    // R5: pointer as source
    do_push(2'd3, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0000_0000_0000_1000, 0);
    do_push(2'd3, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0123_4567_89AB_CDE8, 1);
    // R2: wrap at the stack width, upper bits kept
    do_push(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h1111, 64'hAAAA_BBBB_CCCC_0000, 0);
    do_push(2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 64'h2222, 64'h1234_5678_0000_0002, 0);
    do_push(2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 64'h3333, 64'h0000_0000_0000_0000, 0);
    do_push(2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 64'h4444, 64'h0000_0001_0000_0000, 0);
    // R10: misaligned result
    do_push(2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 64'h5555, 64'h0000_0100, 0);
    // R7: real-mode fault at exactly 1, not at 2
    do_push(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 64'h6666, 64'hFFFF_0000_0000_0001, 0);
    do_push(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 64'h6666, 64'h0000_0000_0000_0002, 0);
    do_push(2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 64'h7777, 64'h0000_0000_0000_0001, 0);
    // R6: register truncation
    do_push(2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'hFEDC_BA98_7654_3210, 64'h9000, 0);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] rv, rs;
      logic [1:0]  os;
      rv = {$urandom, $urandom};
      rs = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) rs[15:0] = 16'h0001;
      os = 2'($urandom_range(0, 2));
      do_push(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), os,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), rv, rs, $urandom_range(0, 3));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule